// File: doc/BRIEF.md
# Serial-Programmed Feedback Divider Control

This block is the digital control path of a clock synthesizer that can shift its output frequency up or down on demand. A host writes a 6-bit feedback-divider value over a three-wire serial link made of a load strobe, a serial clock and a data line. The value is shifted in most significant bit first while the strobe is high. The falling edge of the strobe copies it into a holding register.

A mode input picks the divider that reaches the PLL. In default mode the divider is fixed at the nominal value of 50, whatever has been written. In margining mode the divider is the held value. The synthesizer output equals 12.5 MHz times M divided by 2, so held values from 45 to 55 move the output from -10% to +10% of nominal in 2% steps. The block also reports the percent change of the chosen divider. It raises a flag when the held value lies inside the range where the PLL can lock.

The three serial lines are asynchronous to the block clock. They are synchronised and edge-detected inside the block.

Top module: `margin_div_ctrl`

## Requirements
- R1: After a synchronous reset, the shift register and the held register both contain 50. The outputs are then div_eff = 50, pct_chg = 0 and in_range = 1.
- R2: While ser_ld is high, each rising edge of ser_clk shifts ser_dat in at the low end. After six edges, the first bit sent is bit 5 of the value.
- R3: A high-to-low transition of ser_ld copies the shift register into the held register.
- R4: While ser_ld is low, edges on ser_clk and changes on ser_dat leave the shift register unchanged. A later strobe with no clock edges therefore commits the earlier contents.
- R5: Serial writes are accepted while margin_en is low. The written value appears as soon as margin_en is raised.
- R6: While margin_en is low, div_eff is 50 whatever value is held.
- R7: While margin_en is high, div_eff equals the held value, including values outside 45 to 55.
- R8: Leaving margining mode restores div_eff to 50. Returning to margining mode shows the held value again, without a rewrite.
- R9: When more than six bits are shifted before the strobe falls, only the last six bits sent are kept.
- R10: in_range is 1 exactly when the held value is between 45 and 55 inclusive. It follows the held value in both modes.
- R11: pct_chg is an 8-bit two's-complement value equal to (div_eff - 50) * 2.
- R12: A serial edge or a mode change reaches the outputs within SYNC_STAGES + 3 cycles of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_ld | input | 1 | Load strobe: shifts enabled when high, commit on falling edge |
| margin_en | input | 1 | 0 = nominal divider, 1 = held divider |
| div_eff | output | 6 | Divider value presented to the PLL |
| pct_chg | output | 8 | Signed percent change of div_eff from nominal |
| in_range | output | 1 | Held value lies in the lockable range 45..55 |

## Verification
The held register can be seen at the ports only in margining mode. A bad held value therefore shows on div_eff and pct_chg a few clk cycles after margin_en goes high. It shows on in_range in either mode. A shift register that is wrong through bit order, an extra shift or a shift while the strobe is low stays hidden until the next falling edge of the strobe. For that reason every write is read back through a commit and margining mode. The ignore case commits a strobe that has no clock edges, so stray shifts show up as a changed divider.

// File: rtl/margin_div_pkg.sv
package margin_div_pkg;
    localparam int MW      = 6;
    localparam int PCT_W   = 8;
    localparam int M_NOM   = 50;
    localparam int M_LO    = 45;
    localparam int M_HI    = 55;
    localparam int STEP    = 2;

    typedef logic [MW-1:0] mval_t;

    typedef struct packed {
        logic lvl_ld;
        logic dat;
        logic clk_rise;
        logic ld_fall;
    } ser_evt_t;

    function automatic logic m_in_range(input mval_t m);
        return (int'(m) >= M_LO) && (int'(m) <= M_HI);
    endfunction

    function automatic logic [PCT_W-1:0] m_pct(input mval_t m);
        logic signed [PCT_W-1:0] d;
        d = $signed(PCT_W'(m)) - $signed(PCT_W'(M_NOM));
        return PCT_W'(d * $signed(PCT_W'(STEP)));
    endfunction
endpackage

// File: rtl/ser_frontend.sv
module ser_frontend
    import margin_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     ser_dat,
    input  logic     ser_ld,
    output ser_evt_t evt
);
    localparam int NLINE = 3;

    logic [SYNC_STAGES-1:0][NLINE-1:0] chain;
    logic [NLINE-1:0] synced;
    logic clk_prev, ld_prev;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= {ser_ld, ser_dat, ser_clk};
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            ld_prev  <= 1'b0;
        end else begin
            clk_prev <= synced[0];
            ld_prev  <= synced[2];
        end
    end

    always_comb begin
        evt.lvl_ld   = synced[2];
        evt.dat      = synced[1];
        evt.clk_rise = synced[0] & ~clk_prev;
        evt.ld_fall  = ld_prev & ~synced[2];
    end
endmodule

// File: rtl/div_shift_hold.sv
module div_shift_hold
    import margin_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t evt,
    output mval_t    shreg,
    output mval_t    held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= mval_t'(M_NOM);
        end else if (evt.lvl_ld && evt.clk_rise) begin
            shreg <= {shreg[MW-2:0], evt.dat};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= mval_t'(M_NOM);
        end else if (evt.ld_fall) begin
            held <= shreg;
        end
    end
endmodule

// File: rtl/div_out_sel.sv
module div_out_sel
    import margin_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             margin_en,
    input  mval_t            held,
    output mval_t            div_eff,
    output logic [PCT_W-1:0] pct_chg,
    output logic             in_range
);
    mval_t sel;

    assign sel = margin_en ? held : mval_t'(M_NOM);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_eff  <= mval_t'(M_NOM);
            pct_chg  <= '0;
            in_range <= 1'b1;
        end else begin
            div_eff  <= sel;
            pct_chg  <= m_pct(sel);
            in_range <= m_in_range(held);
        end
    end
endmodule

// File: rtl/margin_div_ctrl.sv
module margin_div_ctrl
    import margin_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_ld,
    input  logic        margin_en,
    output logic [5:0]  div_eff,
    output logic [7:0]  pct_chg,
    output logic        in_range
);
    ser_evt_t evt;
    mval_t    shreg_q, held_q;
    logic     ld_sync, commit_pulse;

    ser_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .evt(evt)
    );

    div_shift_hold u_sh (
        .clk(clk), .rst(rst), .evt(evt), .shreg(shreg_q), .held(held_q)
    );

    div_out_sel u_out (
        .clk(clk), .rst(rst), .margin_en(margin_en), .held(held_q),
        .div_eff(div_eff), .pct_chg(pct_chg), .in_range(in_range)
    );

    assign ld_sync      = evt.lvl_ld;
    assign commit_pulse = evt.ld_fall;
endmodule

// File: rtl/div_ctrl_chk.sv
module div_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       margin_en,
    input logic [5:0] div_eff,
    input logic [7:0] pct_chg,
    input logic       in_range,
    input logic [5:0] held,
    input logic [5:0] shreg,
    input logic       ld_sync,
    input logic       commit
);
    p_nominal_default_r6: assert property (@(posedge clk) disable iff (rst)
        !margin_en |=> div_eff == 6'd50);

    p_margin_pass_r7: assert property (@(posedge clk) disable iff (rst)
        margin_en |=> div_eff == $past(held));

    p_hold_only_on_commit_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(held));

    p_shift_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !ld_sync |=> $stable(shreg));

    p_pct_match_r11: assert property (@(posedge clk) disable iff (rst)
        $signed(pct_chg) == ($signed({2'b00, div_eff}) - 8'sd50) * 8'sd2);

    p_flag_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> in_range == ($past(held) >= 6'd45 && $past(held) <= 6'd55));
endmodule

bind margin_div_ctrl div_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .margin_en(margin_en), .div_eff(div_eff),
    .pct_chg(pct_chg), .in_range(in_range), .held(held_q),
    .shreg(shreg_q), .ld_sync(ld_sync), .commit(commit_pulse)
);

// File: tb/tb_margin_div_ctrl.sv
`timescale 1ns/1ps
module tb_margin_div_ctrl;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, margin_en = 1'b0;
    logic [5:0] div_eff;
    logic [7:0] pct_chg;
    logic       in_range;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    margin_div_ctrl dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .margin_en(margin_en), .div_eff(div_eff),
        .pct_chg(pct_chg), .in_range(in_range)
    );

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n-1; i >= 0; i--) begin
            ser_dat = v[i];
            waitc(HALF);
            ser_clk = 1'b1;
            waitc(HALF);
            ser_clk = 1'b0;
        end
    endtask

    task automatic write_word(input logic [15:0] v, input int n);
        ser_ld = 1'b1;
        waitc(HALF);
        send_bits(v, n);
        waitc(HALF);
        ser_ld = 1'b0;
        waitc(HALF);
    endtask

    task automatic check_all(input string req, input int m, input bit margin);
        int e;
        e = margin ? m : 50;
        check({req, " div_eff"}, int'(div_eff), e);
        check({req, " pct_chg"}, int'($signed(pct_chg)), (e - 50) * 2);
        check({req, " in_range"}, int'(in_range), int'(m >= 45 && m <= 55));
    endtask

    task automatic t_reset();
        margin_en = 1'b1;
        waitc(HALF);
        check_all("R1 reset", 50, 1'b1);
    endtask

    task automatic t_table();
        margin_en = 1'b1;
        for (int m = 45; m <= 55; m++) begin
            write_word(16'(m), 6);
            check_all("R2/R3/R7/R10/R11 table", m, 1'b1);
        end
    endtask

    task automatic t_out_of_range();
        int vals[4] = '{44, 56, 0, 63};
        margin_en = 1'b1;
        foreach (vals[i]) begin
            write_word(16'(vals[i]), 6);
            check_all("R7/R10 out of range", vals[i], 1'b1);
        end
    endtask

    task automatic t_ignore();
        margin_en = 1'b1;
        write_word(16'd47, 6);
        ser_ld = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ser_dat = i[0];
            waitc(HALF);
            ser_clk = 1'b1;
            waitc(HALF);
            ser_clk = 1'b0;
        end
        check_all("R4 ignored before strobe", 47, 1'b1);
        ser_ld = 1'b1;
        waitc(2 * HALF);
        ser_ld = 1'b0;
        waitc(HALF);
        check_all("R4 empty strobe", 47, 1'b1);
    endtask

    task automatic t_default_load();
        margin_en = 1'b0;
        write_word(16'd53, 6);
        check_all("R5/R6 default mode", 53, 1'b0);
        margin_en = 1'b1;
        waitc(5);
        check_all("R5 enter margin", 53, 1'b1);
    endtask

    task automatic t_toggle();
        margin_en = 1'b1;
        write_word(16'd46, 6);
        margin_en = 1'b0;
        waitc(5);
        check_all("R8 leave margin", 46, 1'b0);
        margin_en = 1'b1;
        waitc(5);
        check_all("R8 return margin", 46, 1'b1);
    endtask

    task automatic t_overlong();
        margin_en = 1'b1;
        write_word({6'b111111, 4'b0000, 6'd51}, 16);
        check_all("R9 last six kept", 51, 1'b1);
    endtask

    task automatic t_latency();
        margin_en = 1'b1;
        write_word(16'd54, 6);
        margin_en = 1'b0;
        waitc(5);
        check("R12 mode latency", int'(div_eff), 50);
    endtask

    initial begin : watchdog
        #900000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(2);
        t_reset();
        t_table();
        t_out_of_range();
        t_ignore();
        t_default_load();
        t_toggle();
        t_overlong();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule